// File: doc/BRIEF.md
# Vectored priority interrupt arbiter

This block sits next to a small 8-bit processor core and handles its interrupts. It holds a pending flag and an enable flag for up to fourteen maskable sources, plus one non-maskable software trap flag. It also holds the global enable. While a maskable source is both pending and enabled and the global enable is set, it asks the core to interrupt. The trap asks unconditionally. When the core takes the interrupt, the global enable drops and the core is sent to a fixed common entry address. Setting the global enable again, for example on return from interrupt, re-arms the request.

Software at the common entry later issues a vector-select operation. Only at that moment does the block pick a winner: the highest-ranked source that is then pending and enabled. That winner may differ from the source that caused entry. The block then returns, one cycle later, the ROM addresses of that source's two-byte vector. The page of those addresses comes from the program counter of the select operation. When nothing is active, the select yields a default slot. A helper output joins the two fetched vector bytes into the 15-bit jump target.

Top module: `intarb_top`

## Requirements
- R1: After reset, irq, gie, entry_vld, vec_vld and vec_page_err are 0, and every pending, enable and trap flag is clear.
- R2: A pend_set bit sets its pending flag, and only a pend_clr bit clears it (set wins over clear in the same cycle). A vector-select leaves all pending flags unchanged.
- R3: irq is 1 exactly when the trap flag is set, or when gie is 1 and some source is both pending and enabled.
- R4: A cycle with int_take makes gie 0 in the next cycle. In that next cycle entry_vld is 1 for one cycle and entry_pc is 0x00FF. gie_set makes gie 1 in the next cycle, and gie_clr makes it 0.
- R5: For the selected winner, the low byte of vec_hi_addr is 0xE0 + 2*(i+1) for maskable source index i, and 0xFE for the trap. The rank order is trap, then source 13 down to source 0, so a higher index wins.
- R6: The select uses the flags present in the cycle the select is issued, whatever the value of gie. A source that became active after int_take and ranks higher beats the one that caused entry.
- R7: A select with no source both pending and enabled, and no trap, gives low byte 0xE0 in vec_hi_addr and 0xE1 in vec_lo_addr.
- R8: The page, which is the upper byte of both addresses, is the upper byte of vis_pc. When the low byte of vis_pc is 0xFF, it is that upper byte plus one, wrapping at the top.
- R9: vec_page_err is 1 with vec_vld exactly when the page chosen under R8 is 0.
- R10: vec_vld is a one-cycle pulse in the cycle after vis_go. vec_hi_addr is even, and vec_lo_addr equals vec_hi_addr + 1.
- R11: vec_target equals {rom_hi[6:0], rom_lo}, so bit 7 of the high byte is dropped.
- R12: When an enable write clears a source's enable in the same cycle as that source's request arrives, irq may take either value during that cycle. It must be 0 from the next cycle on, provided no other request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_set | input | NUM_SRC | Per-source request pulses that set pending flags |
| pend_clr | input | NUM_SRC | Software clear mask for pending flags |
| en_wr | input | 1 | Load the enable flags from en_data |
| en_data | input | NUM_SRC | New enable flags |
| trap_set | input | 1 | Set the software trap flag |
| trap_clr | input | 1 | Clear the software trap flag |
| gie_set | input | 1 | Set the global enable (software or return from interrupt) |
| gie_clr | input | 1 | Clear the global enable |
| int_take | input | 1 | Core is taking the interrupt |
| vis_go | input | 1 | Vector-select operation issued |
| vis_pc | input | PC_W | Program counter of the select operation |
| rom_hi | input | 8 | Fetched high vector byte |
| rom_lo | input | 8 | Fetched low vector byte |
| irq | output | 1 | Interrupt request to the core |
| gie | output | 1 | Global enable state |
| entry_vld | output | 1 | One-cycle redirect strobe after int_take |
| entry_pc | output | PC_W | Common entry address |
| vec_vld | output | 1 | Vector address pair valid |
| vec_hi_addr | output | PC_W | ROM address of the vector high byte |
| vec_lo_addr | output | PC_W | ROM address of the vector low byte |
| vec_page_err | output | 1 | Vector table would fall in page 0 |
| vec_target | output | 15 | Jump target formed from the vector bytes |

## Verification
The bench builds the block with its defaults: fourteen maskable sources and a 16-bit program counter. With fourteen sources every slot from 0xE2 up to 0xFC can be reached, the trap slot at 0xFE sits directly above the last maskable one, and the default slot sits below the first. With a 16-bit counter the select can be issued at 0xFFFF, which checks that the page increment wraps to page 0 and raises the page error.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
   // table layout: slot 0 is the idle default, slots 1..MAX_SRC maskable, top slot trap
   localparam int unsigned MAX_SRC    = 14;
   localparam int unsigned NUM_SLOTS  = MAX_SRC + 2;
   localparam int unsigned CODE_W     = $clog2(NUM_SLOTS);
   localparam logic [7:0]  TABLE_BASE = 8'hE0;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned VEC_W      = 2 * BYTE_W - 1;
endpackage

// File: rtl/intarb_src_regs.sv
module intarb_src_regs #(
   parameter int unsigned NUM_SRC = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_set,
   input  logic [NUM_SRC-1:0] pend_clr,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_data,
   input  logic               trap_set,
   input  logic               trap_clr,
   output logic [NUM_SRC-1:0] pend_q,
   output logic [NUM_SRC-1:0] en_q,
   output logic               trap_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
         trap_q <= 1'b0;
      end else begin
         // a new request wins over a software clear in the same cycle
         pend_q <= (pend_q & ~pend_clr) | pend_set;
         if (en_wr) en_q <= en_data;
         trap_q <= (trap_q & ~trap_clr) | trap_set;
      end
   end
endmodule

// File: rtl/intarb_gate.sv
module intarb_gate #(
   parameter int unsigned PC_W     = 16,
   parameter int unsigned ENTRY_PC = 'h00FF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            any_act,
   input  logic            trap_q,
   input  logic            int_take,
   input  logic            gie_set,
   input  logic            gie_clr,
   output logic            irq,
   output logic            gie,
   output logic            entry_vld,
   output logic [PC_W-1:0] entry_pc
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie       <= 1'b0;
         entry_vld <= 1'b0;
      end else begin
         entry_vld <= int_take;
         if (int_take || gie_clr) gie <= 1'b0;
         else if (gie_set)        gie <= 1'b1;
      end
   end

   assign entry_pc = PC_W'(ENTRY_PC);
   assign irq      = trap_q | (gie & any_act);
endmodule

// File: rtl/intarb_prio.sv
module intarb_prio #(
   parameter int unsigned N_IN   = 15,
   parameter int unsigned CODE_W = 4
) (
   input  logic [N_IN-1:0]   act,
   output logic [CODE_W-1:0] code
);
   logic [N_IN-1:0] hit;

   // one-hot winner: a bit wins when nothing above it is active
   for (genvar i = 0; i < N_IN; i++) begin : g_hit
      if (i == N_IN - 1) begin : g_top
         assign hit[i] = act[i];
      end else begin : g_low
         assign hit[i] = act[i] & ~(|act[N_IN-1:i+1]);
      end
   end

   always_comb begin
      code = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (hit[i]) code = code | CODE_W'(i + 1);
      end
   end
endmodule

// File: rtl/intarb_vecgen.sv
module intarb_vecgen
   import intarb_pkg::*;
#(
   parameter int unsigned PC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [PC_W-1:0]   pc,
   input  logic [CODE_W-1:0] code,
   output logic              vld,
   output logic [PC_W-1:0]   hi_addr,
   output logic [PC_W-1:0]   lo_addr,
   output logic              page_err
);
   localparam int unsigned PAGE_W = PC_W - BYTE_W;

   logic [PAGE_W-1:0] page;
   logic [BYTE_W-1:0] ofs;

   // a select at the last byte of a page reads the table of the next page
   assign page = pc[PC_W-1:BYTE_W] + PAGE_W'(pc[BYTE_W-1:0] == '1);
   assign ofs  = TABLE_BASE + BYTE_W'({code, 1'b0});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld      <= 1'b0;
         hi_addr  <= '0;
         lo_addr  <= '0;
         page_err <= 1'b0;
      end else begin
         vld <= go;
         if (go) begin
            hi_addr  <= {page, ofs};
            lo_addr  <= {page, ofs | BYTE_W'(1)};
            page_err <= (page == '0);
         end else begin
            page_err <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/intarb_top.sv
module intarb_top
   import intarb_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 14,
   parameter int unsigned PC_W     = 16,
   parameter int unsigned ENTRY_PC = 'h00FF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_set,
   input  logic [NUM_SRC-1:0] pend_clr,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_data,
   input  logic               trap_set,
   input  logic               trap_clr,
   input  logic               gie_set,
   input  logic               gie_clr,
   input  logic               int_take,
   input  logic               vis_go,
   input  logic [PC_W-1:0]    vis_pc,
   input  logic [7:0]         rom_hi,
   input  logic [7:0]         rom_lo,
   output logic               irq,
   output logic               gie,
   output logic               entry_vld,
   output logic [PC_W-1:0]    entry_pc,
   output logic               vec_vld,
   output logic [PC_W-1:0]    vec_hi_addr,
   output logic [PC_W-1:0]    vec_lo_addr,
   output logic               vec_page_err,
   output logic [14:0]        vec_target
);
   localparam int unsigned N_IN = MAX_SRC + 1;

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("intarb_top: NUM_SRC must lie in 1..%0d", MAX_SRC);
   end
   if (PC_W <= BYTE_W || PC_W > 32) begin : g_bad_pc
      $error("intarb_top: PC_W must lie in %0d..32", BYTE_W + 1);
   end

   logic [NUM_SRC-1:0] pend_q, en_q;
   logic               trap_q;
   logic [NUM_SRC-1:0] live;
   logic [MAX_SRC-1:0] live_full;
   logic [CODE_W-1:0]  code;

   intarb_src_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_set (pend_set),
      .pend_clr (pend_clr),
      .en_wr    (en_wr),
      .en_data  (en_data),
      .trap_set (trap_set),
      .trap_clr (trap_clr),
      .pend_q   (pend_q),
      .en_q     (en_q),
      .trap_q   (trap_q)
   );

   assign live = pend_q & en_q;

   // the trap keeps the top slot whatever the number of maskable sources
   if (NUM_SRC == MAX_SRC) begin : g_full
      assign live_full = live;
   end else begin : g_pad
      assign live_full = {{(MAX_SRC - NUM_SRC){1'b0}}, live};
   end

   intarb_gate #(.PC_W(PC_W), .ENTRY_PC(ENTRY_PC)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_act   (|live),
      .trap_q    (trap_q),
      .int_take  (int_take),
      .gie_set   (gie_set),
      .gie_clr   (gie_clr),
      .irq       (irq),
      .gie       (gie),
      .entry_vld (entry_vld),
      .entry_pc  (entry_pc)
   );

   intarb_prio #(.N_IN(N_IN), .CODE_W(CODE_W)) u_prio (
      .act  ({trap_q, live_full}),
      .code (code)
   );

   intarb_vecgen #(.PC_W(PC_W)) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (vis_go),
      .pc       (vis_pc),
      .code     (code),
      .vld      (vec_vld),
      .hi_addr  (vec_hi_addr),
      .lo_addr  (vec_lo_addr),
      .page_err (vec_page_err)
   );

   assign vec_target = {rom_hi[BYTE_W-2:0], rom_lo};
endmodule

// File: rtl/intarb_chk.sv
module intarb_chk #(
   parameter int unsigned PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            int_take,
   input logic            gie_clr,
   input logic            irq,
   input logic            gie,
   input logic            trap_q,
   input logic            entry_vld,
   input logic            vis_go,
   input logic            vec_vld,
   input logic [PC_W-1:0] vec_hi_addr,
   input logic [PC_W-1:0] vec_lo_addr,
   input logic            vec_page_err
);
   // R4
   take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_take |=> !gie);
   // R4
   entry_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_vld |-> $past(int_take));
   // R3
   irq_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie && !trap_q) |-> !irq);
   // R10
   vld_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld |-> $past(vis_go));
   // R10
   pair_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld |-> (!vec_hi_addr[0] && vec_lo_addr == vec_hi_addr + PC_W'(1)));
   // R5
   slot_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld |-> (vec_hi_addr[7:0] >= 8'hE0));
   // R9
   page_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld |-> (vec_page_err == (vec_hi_addr[PC_W-1:8] == '0)));
   // R9
   no_flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_vld |-> !vec_page_err);
endmodule

bind intarb_top intarb_chk #(.PC_W(PC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .int_take     (int_take),
   .gie_clr      (gie_clr),
   .irq          (irq),
   .gie          (gie),
   .trap_q       (trap_q),
   .entry_vld    (entry_vld),
   .vis_go       (vis_go),
   .vec_vld      (vec_vld),
   .vec_hi_addr  (vec_hi_addr),
   .vec_lo_addr  (vec_lo_addr),
   .vec_page_err (vec_page_err)
);

// File: tb/test_intarb_top.sv
module test_intarb_top;
   localparam int NS = 14;
   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] pend_set = '0, pend_clr = '0, en_data = '0;
   logic          en_wr = 0, trap_set = 0, trap_clr = 0;
   logic          gie_set = 0, gie_clr = 0, int_take = 0, vis_go = 0;
   logic [PW-1:0] vis_pc = '0;
   logic [7:0]    rom_hi = '0, rom_lo = '0;
   logic          irq, gie, entry_vld, vec_vld, vec_page_err;
   logic [PW-1:0] entry_pc, vec_hi_addr, vec_lo_addr;
   logic [14:0]   vec_target;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   intarb_top #(.NUM_SRC(NS), .PC_W(PW)) i_intarb_top (
      .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .pend_clr(pend_clr),
      .en_wr(en_wr), .en_data(en_data), .trap_set(trap_set), .trap_clr(trap_clr),
      .gie_set(gie_set), .gie_clr(gie_clr), .int_take(int_take),
      .vis_go(vis_go), .vis_pc(vis_pc), .rom_hi(rom_hi), .rom_lo(rom_lo),
      .irq(irq), .gie(gie), .entry_vld(entry_vld), .entry_pc(entry_pc),
      .vec_vld(vec_vld), .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr),
      .vec_page_err(vec_page_err), .vec_target(vec_target)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reference winner code: trap, then highest pending-and-enabled index
   function automatic int ref_code(logic [NS-1:0] p, logic [NS-1:0] e, logic t);
      if (t) return 15;
      for (int i = NS - 1; i >= 0; i--) if (p[i] && e[i]) return i + 1;
      return 0;
   endfunction

   task automatic set_state(logic [NS-1:0] p, logic [NS-1:0] e, logic t);
      @(negedge clk); pend_clr = '1; trap_clr = 1;
      @(negedge clk); pend_clr = '0; trap_clr = 0;
      pend_set = p; trap_set = t; en_wr = 1; en_data = e;
      @(negedge clk); pend_set = '0; trap_set = 0; en_wr = 0;
   endtask

   // issue a select and check the pair one cycle later
   task automatic select_chk(string req, logic [PW-1:0] pc, logic [7:0] pg,
                             int code, logic err);
      logic [7:0] ofs;
      ofs = 8'hE0 + 8'(2 * code);
      @(negedge clk); vis_go = 1; vis_pc = pc;
      @(negedge clk); vis_go = 0;
      check({req, " vld"}, vec_vld, 1);
      check({req, " hi"}, vec_hi_addr, {pg, ofs});
      check({req, " lo"}, vec_lo_addr, {pg, ofs + 8'd1});
      check({req, " err"}, vec_page_err, err);
      @(negedge clk);
      check({req, " pulse"}, vec_vld, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 irq", irq, 0);
      check("R1 gie", gie, 0);
      check("R1 entry", entry_vld, 0);
      check("R1 vld", vec_vld, 0);
      check("R1 err", vec_page_err, 0);
      select_chk("R1 empty", 16'h0310, 8'h03, 0, 0);
   endtask

   task automatic t_irq_gate;
      set_state(14'h0001, 14'h0001, 0);
      check("R3 gie off", irq, 0);
      @(negedge clk); gie_set = 1;
      @(negedge clk); gie_set = 0;
      check("R3 gie on", irq, 1);
      set_state(14'h0001, 14'h0000, 0);
      check("R3 masked", irq, 0);
      @(negedge clk); gie_clr = 1;
      @(negedge clk); gie_clr = 0;
      check("R4 gie_clr", gie, 0);
      set_state(14'h0000, 14'h0000, 1);
      check("R3 trap unmaskable", irq, 1);
   endtask

   task automatic t_take;
      set_state(14'h0004, 14'h3FFF, 0);
      @(negedge clk); gie_set = 1;
      @(negedge clk); gie_set = 0;
      @(negedge clk); int_take = 1;
      @(negedge clk); int_take = 0;
      check("R4 gie cleared", gie, 0);
      check("R4 entry strobe", entry_vld, 1);
      check("R4 entry pc", entry_pc, 16'h00FF);
      check("R3 irq after take", irq, 0);
      @(negedge clk);
      check("R4 strobe one cycle", entry_vld, 0);
      // higher source arrives after entry and wins the select
      pend_set = 14'h0400;
      @(negedge clk); pend_set = '0;
      select_chk("R6 late winner", 16'h0120, 8'h01, 11, 0);
      @(negedge clk); pend_clr = 14'h0400;
      @(negedge clk); pend_clr = '0;
      select_chk("R2 still pending", 16'h0120, 8'h01, 3, 0);
      @(negedge clk); gie_set = 1;
      @(negedge clk); gie_set = 0;
      check("R4 return sets gie", gie, 1);
      check("R2 irq again", irq, 1);
      // set wins over clear
      @(negedge clk); pend_clr = 14'h0004; pend_set = 14'h0004;
      @(negedge clk); pend_clr = '0; pend_set = '0;
      check("R2 set over clear", irq, 1);
      @(negedge clk); gie_clr = 1;
      @(negedge clk); gie_clr = 0;
   endtask

   task automatic t_random;
      for (int n = 0; n < 60; n++) begin
         logic [NS-1:0] p, e;
         logic t;
         p = NS'($urandom);
         e = NS'($urandom);
         t = ($urandom % 8) == 0;
         set_state(p, e, t);
         select_chk("R5 ranked", 16'h0240, 8'h02, ref_code(p, e, t), 0);
      end
      set_state(14'h2000, 14'h2000, 0);
      select_chk("R5 top source", 16'h0240, 8'h02, 14, 0);
      set_state(14'h2000, 14'h2000, 1);
      select_chk("R5 trap over all", 16'h0240, 8'h02, 15, 0);
   endtask

   task automatic t_default;
      set_state(14'h3FFF, 14'h0000, 0);
      select_chk("R7 none enabled", 16'h0500, 8'h05, 0, 0);
   endtask

   task automatic t_page;
      set_state(14'h0001, 14'h0001, 0);
      select_chk("R8 last byte", 16'h01FF, 8'h02, 1, 0);
      select_chk("R8 same page", 16'h0255, 8'h02, 1, 0);
      select_chk("R9 page1 ok", 16'h00FF, 8'h01, 1, 0);
      select_chk("R9 page0", 16'h0042, 8'h00, 1, 1);
      select_chk("R9 wrap", 16'hFFFF, 8'h00, 1, 1);
   endtask

   task automatic t_target;
      @(negedge clk); rom_hi = 8'hFF; rom_lo = 8'h34;
      #1 check("R11 top bit", vec_target, 15'h7F34);
      rom_hi = 8'h12; rom_lo = 8'hAB;
      #1 check("R11 plain", vec_target, 15'h12AB);
   endtask

   task automatic t_race;
      set_state(14'h0000, 14'h0008, 0);
      @(negedge clk); gie_set = 1;
      @(negedge clk); gie_set = 0;
      pend_set = 14'h0008; en_wr = 1; en_data = 14'h0000;
      #1 checks++;  // R12: either value is accepted in this cycle
      @(negedge clk); pend_set = '0; en_wr = 0;
      check("R12 after race", irq, 0);
      @(negedge clk); gie_clr = 1;
      @(negedge clk); gie_clr = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_irq_gate();
      t_take();
      t_random();
      t_default();
      t_page();
      t_target();
      t_race();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule